// File: doc/BRIEF.md
# Configurable Memory Column Decoder

This block produces the chip selects for a static RAM board on an 8-bit microcomputer bus. The board holds eight columns of 4 KB, each column one byte wide. Each column can be placed at any of the sixteen 4 KB windows of a 64 KB address space, and the windows are named by the top four address bits. Each column has its own configuration slot, loaded through a small write port, that holds a window number and an enable bit.

Two straps can further restrict the decode. When extended addressing is enabled, the two bits above the 16-bit address must equal a 2-bit page setting. That setting places the board in the 64 KB page that starts at 0 K, 64 K, 128 K or 192 K. When phantom support is enabled, pulling the phantom input low deselects the entire board. The outputs are eight active-low column selects, plus a flag that turns on the data buffers whenever any column is selected.

Top module: `mem_bank_decode`

## Requirements
- R1: After a synchronous reset every column slot is disabled, so all eight selects are high and the board flag is low for any address.
- R2: An enabled column whose window number equals addr[15:12] drives its select low. This needs the request strobe high and both qualifiers (page, phantom) passing. Select bit i drives column i.
- R3: A column whose enable bit is clear never drives its select low, whatever its window number is.
- R4: When two or more enabled columns hold the same window, only the lowest-numbered one is selected. At most one select is low at any time.
- R5: While the memory request strobe is low, every select is high.
- R6: With extended addressing enabled, any select is low only when the two extended address bits equal the 2-bit page setting. Setting 0 is the page at 0 K, setting 1 at 64 K, setting 2 at 128 K and setting 3 at 192 K.
- R7: With extended addressing disabled, the extended address bits and the page setting have no effect on the selects.
- R8: With phantom support enabled, a low phantom input holds every select high. With phantom support disabled, the phantom input has no effect.
- R9: The board flag is high exactly when one of the column selects is low.
- R10: A configuration write to slot cfg_col updates the window and enable of that slot only. The new values govern decode from the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration slots |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one column slot |
| cfg_col | input | 3 | Column slot to write |
| cfg_win | input | 4 | Window number to store |
| cfg_en | input | 1 | Enable bit to store |
| ext_en | input | 1 | Strap: compare the extended address bits |
| page_set | input | 2 | Strap: 64 KB page the board occupies |
| phantom_en | input | 1 | Strap: honour the phantom input |
| addr | input | 16 | Bus address |
| ext_addr | input | 2 | Extended address bits 17:16 |
| mreq | input | 1 | Memory request strobe, active high |
| phantom_n | input | 1 | Phantom input, active low |
| col_sel_n | output | 8 | Column selects, active low |
| board_sel | output | 1 | High when any column is selected |

## Verification
Only the configuration slots hold state, and the decode after them has no registers. A corrupted window or enable bit therefore shows at the ports on the first access to the affected window. A column may answer at the wrong window, stay silent at its own window, or two columns may collide. For that reason the bench fills every column with a deliberate layout, which includes one disabled slot and two overlapping pairs. It then probes each window, reading the selects in the same cycle as the address. It also rewrites slots and checks the change one edge later.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    localparam int WIN_W = 4;

    typedef struct packed {
        logic             en;
        logic [WIN_W-1:0] win;
    } col_cfg_t;

    function automatic logic page_hit(input logic ext_on,
                                      input logic [1:0] ext_bits,
                                      input logic [1:0] page);
        return !ext_on || (ext_bits == page);
    endfunction

endpackage

// File: rtl/bankdec_cfg_regs.sv
module bankdec_cfg_regs
    import bankdec_pkg::*;
#(
    parameter int NUM_COLS = 8,
    localparam int IDX_W = $clog2(NUM_COLS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [WIN_W-1:0]          win,
    input  logic                      en,
    output col_cfg_t [NUM_COLS-1:0]   cfg
);

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                cfg[i].en  <= en;
                cfg[i].win <= win;
            end
        end
    end

endmodule

// File: rtl/bankdec_match.sv
module bankdec_match
    import bankdec_pkg::*;
#(
    parameter int NUM_COLS = 8
) (
    input  col_cfg_t [NUM_COLS-1:0] cfg,
    input  logic [WIN_W-1:0]        win_addr,
    input  logic                    qual,
    output logic [NUM_COLS-1:0]     hit
);

    for (genvar i = 0; i < NUM_COLS; i++) begin : g_cmp
        assign hit[i] = qual && cfg[i].en && (cfg[i].win == win_addr);
    end

endmodule

// File: rtl/bankdec_prio.sv
module bankdec_prio #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);

    logic [WIDTH:0] taken;

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < WIDTH; i++) begin : g_chain
        assign grant[i]   = req[i] && !taken[i];
        assign taken[i+1] = taken[i] || req[i];
    end

endmodule

// File: rtl/mem_bank_decode.sv
module mem_bank_decode
    import bankdec_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int ADDR_W   = 16,
    parameter int PAGE_W   = 2,
    localparam int IDX_W   = $clog2(NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_col,
    input  logic [WIN_W-1:0]    cfg_win,
    input  logic                cfg_en,
    input  logic                ext_en,
    input  logic [PAGE_W-1:0]   page_set,
    input  logic                phantom_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_W-1:0]   ext_addr,
    input  logic                mreq,
    input  logic                phantom_n,
    output logic [NUM_COLS-1:0] col_sel_n,
    output logic                board_sel
);

    col_cfg_t [NUM_COLS-1:0] cfg;
    logic [NUM_COLS-1:0]     hit;
    logic [NUM_COLS-1:0]     grant;
    logic                    page_ok;
    logic                    phantom_ok;
    logic                    qual;

    bankdec_cfg_regs #(.NUM_COLS(NUM_COLS)) u_regs (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .idx (cfg_col),
        .win (cfg_win),
        .en  (cfg_en),
        .cfg (cfg)
    );

    assign page_ok    = page_hit(ext_en, ext_addr, page_set);
    assign phantom_ok = !phantom_en || phantom_n;
    assign qual       = mreq && page_ok && phantom_ok;

    bankdec_match #(.NUM_COLS(NUM_COLS)) u_match (
        .cfg      (cfg),
        .win_addr (addr[ADDR_W-1 -: WIN_W]),
        .qual     (qual),
        .hit      (hit)
    );

    bankdec_prio #(.WIDTH(NUM_COLS)) u_prio (
        .req   (hit),
        .grant (grant)
    );

    assign col_sel_n = ~grant;
    assign board_sel = |grant;

endmodule

// File: rtl/bankdec_chk.sv
module bankdec_chk #(
    parameter int NUM_COLS = 8,
    parameter int PAGE_W   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                ext_en,
    input logic [PAGE_W-1:0]   page_set,
    input logic [PAGE_W-1:0]   ext_addr,
    input logic                phantom_en,
    input logic                phantom_n,
    input logic                mreq,
    input logic [NUM_COLS-1:0] col_sel_n,
    input logic                board_sel
);

    a_r4_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~col_sel_n));

    a_r5_idle_strobe: assert property (@(posedge clk) disable iff (rst)
        !mreq |-> (&col_sel_n));

    a_r6_page_miss: assert property (@(posedge clk) disable iff (rst)
        (ext_en && ext_addr != page_set) |-> (&col_sel_n));

    a_r8_phantom_off: assert property (@(posedge clk) disable iff (rst)
        (phantom_en && !phantom_n) |-> (&col_sel_n));

    a_r9_flag_match: assert property (@(posedge clk) disable iff (rst)
        board_sel == ($countones(~col_sel_n) == 1));

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (&col_sel_n && !board_sel));

endmodule

bind mem_bank_decode bankdec_chk #(
    .NUM_COLS (NUM_COLS),
    .PAGE_W   (PAGE_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ext_en     (ext_en),
    .page_set   (page_set),
    .ext_addr   (ext_addr),
    .phantom_en (phantom_en),
    .phantom_n  (phantom_n),
    .mreq       (mreq),
    .col_sel_n  (col_sel_n),
    .board_sel  (board_sel)
);

// File: tb/mem_bank_decode_tb.sv
module mem_bank_decode_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_col;
    logic [3:0] cfg_win;
    logic       cfg_en;
    logic       ext_en;
    logic [1:0] page_set;
    logic       phantom_en;
    logic [15:0] addr;
    logic [1:0] ext_addr;
    logic       mreq;
    logic       phantom_n;
    logic [7:0] col_sel_n;
    logic       board_sel;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mem_bank_decode dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_col(cfg_col),
        .cfg_win(cfg_win), .cfg_en(cfg_en), .ext_en(ext_en),
        .page_set(page_set), .phantom_en(phantom_en), .addr(addr),
        .ext_addr(ext_addr), .mreq(mreq), .phantom_n(phantom_n),
        .col_sel_n(col_sel_n), .board_sel(board_sel)
    );

    // {window[15:12], ext[11:10], mreq[9], phantom_n[8], expected selects[7:0]}
    localparam logic [15:0] VEC [11] = '{
        {4'h0, 2'd2, 1'b1, 1'b1, 8'hFE},   // R2
        {4'h1, 2'd2, 1'b1, 1'b1, 8'hFD},   // R2
        {4'h3, 2'd2, 1'b1, 1'b1, 8'hFB},   // R4 col2 over col3
        {4'h5, 2'd2, 1'b1, 1'b1, 8'hFF},   // R3 col4 disabled
        {4'h8, 2'd2, 1'b1, 1'b1, 8'hDF},   // R4 col5 over col7
        {4'hF, 2'd2, 1'b1, 1'b1, 8'hBF},   // R2
        {4'h2, 2'd2, 1'b1, 1'b1, 8'hFF},   // R2 empty window
        {4'h0, 2'd1, 1'b1, 1'b1, 8'hFF},   // R6
        {4'hF, 2'd3, 1'b1, 1'b1, 8'hFF},   // R6
        {4'h1, 2'd2, 1'b0, 1'b1, 8'hFF},   // R5
        {4'h1, 2'd2, 1'b1, 1'b0, 8'hFF}    // R8
    };

    task automatic check(input string req, input logic [7:0] exp_sel);
        total++;
        if (col_sel_n !== exp_sel) begin
            bad++;
            $display("FAIL %s col_sel_n actual=%h expected=%h", req, col_sel_n, exp_sel);
        end
        total++;
        if (board_sel !== (exp_sel != 8'hFF)) begin
            bad++;
            $display("FAIL R9 (%s) board_sel actual=%b expected=%b",
                     req, board_sel, exp_sel != 8'hFF);
        end
    endtask

    task automatic wr(input logic [2:0] c, input logic [3:0] w, input logic e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_col = c; cfg_win = w; cfg_en = e;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [3:0] w, input logic [1:0] x,
                         input logic m, input logic p);
        @(negedge clk);
        addr = {w, 12'h7A3}; ext_addr = x; mreq = m; phantom_n = p;
        #1;
    endtask

    initial begin
        #50000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_col = '0; cfg_win = '0; cfg_en = 1'b0;
        ext_en = 1'b1; page_set = 2'd2; phantom_en = 1'b1;
        addr = '0; ext_addr = 2'd2; mreq = 1'b1; phantom_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: nothing enabled after reset
        for (int w = 0; w < 16; w += 5) begin
            probe(4'(w), 2'd2, 1'b1, 1'b1);
            check("R1", 8'hFF);
        end

        // R10: load layout
        wr(3'd0, 4'h0, 1'b1);
        wr(3'd1, 4'h1, 1'b1);
        wr(3'd2, 4'h3, 1'b1);
        wr(3'd3, 4'h3, 1'b1);
        wr(3'd4, 4'h5, 1'b0);
        wr(3'd5, 4'h8, 1'b1);
        wr(3'd6, 4'hF, 1'b1);
        wr(3'd7, 4'h8, 1'b1);

        for (int i = 0; i < 11; i++) begin
            probe(VEC[i][15:12], VEC[i][11:10], VEC[i][9], VEC[i][8]);
            check("R2-table", VEC[i][7:0]);
        end

        // R7: extended compare off
        ext_en = 1'b0;
        probe(4'h1, 2'd0, 1'b1, 1'b1);
        check("R7", 8'hFD);
        probe(4'hF, 2'd3, 1'b1, 1'b1);
        check("R7", 8'hBF);
        ext_en = 1'b1;

        // R6: other page settings
        page_set = 2'd0;
        probe(4'h0, 2'd0, 1'b1, 1'b1);
        check("R6", 8'hFE);
        probe(4'h0, 2'd2, 1'b1, 1'b1);
        check("R6", 8'hFF);
        page_set = 2'd3;
        probe(4'h0, 2'd3, 1'b1, 1'b1);
        check("R6", 8'hFE);
        page_set = 2'd2;

        // R8: phantom ignored when support off
        phantom_en = 1'b0;
        probe(4'h8, 2'd2, 1'b1, 1'b0);
        check("R8", 8'hDF);
        phantom_en = 1'b1;

        // R10: enable col4, takes effect right after the write edge
        @(negedge clk);
        addr = 16'h5123; ext_addr = 2'd2; mreq = 1'b1; phantom_n = 1'b1;
        cfg_we = 1'b1; cfg_col = 3'd4; cfg_win = 4'h5; cfg_en = 1'b1;
        #1 check("R10 before edge", 8'hFF);
        @(negedge clk); cfg_we = 1'b0;
        #1 check("R10", 8'hEF);

        // R3: disable col2, col3 takes window 3 (R4 fallback)
        wr(3'd2, 4'h3, 1'b0);
        probe(4'h3, 2'd2, 1'b1, 1'b1);
        check("R3", 8'hF7);
        // R4: move col0 onto window 8 and it beats col5
        wr(3'd0, 4'h8, 1'b1);
        probe(4'h8, 2'd2, 1'b1, 1'b1);
        check("R4", 8'hFE);
        probe(4'h0, 2'd2, 1'b1, 1'b1);
        check("R10 old window", 8'hFF);

        // R1: reset mid run clears all slots
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe(4'h1, 2'd2, 1'b1, 1'b1);
        check("R1", 8'hFF);
        probe(4'hF, 2'd2, 1'b1, 1'b1);
        check("R1", 8'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule